// File: doc/BRIEF.md
# Multicart Outer Bank Combiner

This block sits between the bank-switching core of a multi-game cartridge and its memories. Software writes four 8-bit outer setup registers through a CPU window whose address nibble is 0x5. From them the block picks which of three inner bank-switching cores is live: a scanline-counter core, a serial-shift core or a cycle-timer core. It then narrows the raw PRG and CHR bank numbers from that core with an AND mask and fills the freed upper bits with an outer value. This confines each game to its own slice of ROM.

Two fixed modes bypass the inner core. In the first, one PRG block of 8, 16 or 32 KiB is mapped with no inner banking. In the second, one 8 KiB CHR block is mapped. A CHR-RAM select can replace CHR ROM. When it is active, the CHR ROM joins the PRG space, so the outer PRG limit widens. Reads in the window return a counter that advances on each reset. This lets a menu program pick a different game on every reset. When the timer core is live, the block also rewrites the register-select address lines that go to the inner core.

Top module: `multicart_bank_combiner`

## Requirements
- R1: A write with `cpu_wr` high and `cpu_addr[15:12]` = 0x5 stores `cpu_wdata` into setup register `cpu_addr[1:0]`. The outputs reflect it from the next clock cycle. A write outside that window changes nothing.
- R2: A read with `cpu_rd` high in the same window makes `cpu_rdata` equal to the reset counter (zero-extended) one cycle later. Any other cycle makes `cpu_rdata` zero one cycle later.
- R3: While `por` is high, all four registers and the reset counter clear. On each rising edge of `rst`, the registers clear and the counter advances by exactly one, wrapping at its width.
- R4: `core_sel` is 0 (scanline core) when reg0 bit1 = 0, 2 (timer core) when reg0[1:0] = 3, and 1 (serial core) when reg0[1:0] = 2.
- R5: The PRG inner mask is 0x00 if reg2 bit4 = 1, otherwise 0x0F if reg2 bit2 = 1, otherwise 0x1F. The PRG outer value is reg1 >> 1, ANDed with the bank limit, with the mask bits cleared. The bank limit is PRG_ROM_BANKS-1. When CHR-RAM is selected, it is PRG_ROM_BANKS+CHR_ROM_BANKS-1.
- R6: When reg2 bit4 = 0 and the scanline or timer core is live, each 8 KiB PRG window w (0..3) outputs (inner[w] & mask) | outer.
- R7: With the serial core and reg2 bit4 = 0, inner PRG numbers are in 16 KiB units. Window w outputs 2*((inner[w] & (mask>>1)) | (outer>>1)) + (w mod 2).
- R8: When reg2 bit4 = 1, the PRG windows are fixed. If reg2 bit3 = 1, every window outputs the outer value. Otherwise, if reg2 bit2 = 1, window w outputs 2*(outer/2) + (w mod 2). Otherwise it outputs 4*(outer/4) + w.
- R9: The CHR inner mask is 0x00 if reg2 bit6 = 1, otherwise 0x7F if bit5 = 1, otherwise 0x1F if bit4 = 1, otherwise 0xFF. The CHR outer value is (reg0 << 1) with the mask bits cleared. For the scanline or timer core, 1 KiB window w (0..7) outputs (inner[w] & mask) | outer.
- R10: With the serial core, inner CHR numbers are in 4 KiB units. Window w outputs 4*((inner[w] & (mask>>2)) | (outer>>2)) + (w mod 4).
- R11: With reg2 bit6 = 1 and CHR-RAM not selected, CHR window w outputs 8*(outer/8) + w.
- R12: When reg2 bit0 = 1 and HAS_CHR_RAM = 1, `chr_ram_sel` is 1 and CHR window w outputs w. In every other case, `chr_ram_sel` is 0.
- R13: When the timer core is live and `cpu_addr[11]` = 1, `core_addr` equals `cpu_addr` with bits 0/1 swapped and bits 2/3 swapped. In every other case, `core_addr` equals `cpu_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; clears the setup registers and advances the counter on its rising edge |
| por | input | 1 | Synchronous power-on clear of all state |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Registered read data from the window |
| prg_inner | input | 32 | Four raw 8-bit PRG bank numbers from the inner core, window 0 in the low byte |
| chr_inner | input | 64 | Eight raw 8-bit CHR bank numbers from the inner core, window 0 in the low byte |
| prg_bank | output | 32 | Four final 8 KiB PRG bank numbers, 8 bits each |
| chr_bank | output | 72 | Eight final 1 KiB CHR bank numbers, 9 bits each |
| core_sel | output | 2 | Live inner core: 0 scanline, 1 serial, 2 timer |
| chr_ram_sel | output | 1 | CHR accesses go to RAM |
| core_addr | output | 16 | Address passed to the inner core, rewritten in timer mode |

## Verification
The bench builds the block with 16 PRG banks and 16 CHR banks, with CHR-RAM present. This makes the ROM-only bank limit 0x0F, narrower than the 0x1F inner mask. Large reg1 values are therefore visibly cut off. Selecting CHR-RAM widens the limit to 0x1F, so the switch in limit is observable at the PRG outputs. Sweeps of reg0, reg1 and reg2 across all core and fixed modes, with fresh inner bank numbers every cycle, reach every masking path. Repeated resets walk the counter.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  localparam int REG_W     = 8;
  localparam int REG_N     = 4;
  localparam int IN_W      = 8;
  localparam int PRG_WINS  = 4;
  localparam int CHR_WINS  = 8;
  localparam int PRG_OUT_W = 8;
  localparam int CHR_OUT_W = 9;
  localparam int ADDR_W    = 16;

  typedef enum logic [1:0] {
    CORE_SCANLINE = 2'd0,
    CORE_SERIAL   = 2'd1,
    CORE_TIMER    = 2'd2
  } core_e;

  typedef logic [REG_N-1:0][REG_W-1:0] cfg_t;
endpackage

// File: rtl/mbc_regs.sv
module mbc_regs
  import mbc_pkg::*;
#(
  parameter int         DIP_W  = 8,
  parameter int         DATA_W = 8,
  parameter logic [3:0] WIN_NIB = 4'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic [3:0]        addr_nib,
  input  logic [1:0]        addr_sel,
  input  logic [REG_W-1:0]  wdata,
  input  logic              wr,
  input  logic              rd,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] rdata
);
  logic             hit;
  logic             rst_q;
  logic [DIP_W-1:0] dip;

  assign hit = (addr_nib == WIN_NIB);

  always_ff @(posedge clk) begin
    if (por) begin
      cfg   <= '0;
      dip   <= '0;
      rst_q <= 1'b0;
      rdata <= '0;
    end else begin
      rst_q <= rst;
      rdata <= (rd && hit) ? DATA_W'(dip) : '0;
      if (rst) begin
        cfg <= '0;
        if (!rst_q) dip <= dip + 1'b1;
      end else if (wr && hit) begin
        cfg[addr_sel] <= wdata;
      end
    end
  end

  // R1
  wr_store_chk: assert property (@(posedge clk) disable iff (por)
    (wr && hit && !rst) |=> cfg[$past(addr_sel)] == $past(wdata));

  // R3
  dip_step_chk: assert property (@(posedge clk) disable iff (por)
    $rose(rst) |=> dip == DIP_W'($past(dip) + 1'b1));

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (por)
    !(rd && hit) |=> rdata == '0);
endmodule

// File: rtl/mbc_mask.sv
module mbc_mask
  import mbc_pkg::*;
#(
  parameter int PRG_ROM_BANKS = 32,
  parameter int CHR_ROM_BANKS = 32,
  parameter bit HAS_CHR_RAM   = 1'b1
) (
  input  cfg_t                 cfg,
  output logic [PRG_OUT_W-1:0] prg_and,
  output logic [PRG_OUT_W-1:0] prg_or,
  output logic [CHR_OUT_W-1:0] chr_and,
  output logic [CHR_OUT_W-1:0] chr_or,
  output logic                 fix_prg,
  output logic                 fix_prg8,
  output logic                 fix_prg16,
  output logic                 fix_chr,
  output logic                 ram_sel,
  output core_e                core
);
  localparam int LIM_ROM = PRG_ROM_BANKS - 1;
  localparam int LIM_RAM = PRG_ROM_BANKS + CHR_ROM_BANKS - 1;

  logic [PRG_OUT_W-1:0] lim;
  logic                 unused_cfg;

  assign unused_cfg = ^{cfg[3], cfg[2][7], cfg[1][0]};

  assign ram_sel   = cfg[2][0] && HAS_CHR_RAM;
  assign fix_prg   = cfg[2][4];
  assign fix_prg8  = cfg[2][3];
  assign fix_prg16 = cfg[2][2];
  assign fix_chr   = cfg[2][6];

  always_comb begin
    if (!cfg[0][1])      core = CORE_SCANLINE;
    else if (cfg[0][0])  core = CORE_TIMER;
    else                 core = CORE_SERIAL;
  end

  always_comb begin
    lim = ram_sel ? PRG_OUT_W'(LIM_RAM) : PRG_OUT_W'(LIM_ROM);
    if (fix_prg)        prg_and = '0;
    else if (cfg[2][2]) prg_and = PRG_OUT_W'(8'h0F);
    else                prg_and = PRG_OUT_W'(8'h1F);
    prg_or = PRG_OUT_W'({1'b0, cfg[1][7:1]}) & lim & ~prg_and;
  end

  always_comb begin
    if (cfg[2][6])      chr_and = '0;
    else if (cfg[2][5]) chr_and = CHR_OUT_W'(9'h07F);
    else if (cfg[2][4]) chr_and = CHR_OUT_W'(9'h01F);
    else                chr_and = CHR_OUT_W'(9'h0FF);
    chr_or = {cfg[0], 1'b0} & ~chr_and;
  end
endmodule

// File: rtl/mbc_prg_map.sv
module mbc_prg_map
  import mbc_pkg::*;
(
  input  logic                          clk,
  input  logic                          por,
  input  logic [PRG_WINS*IN_W-1:0]      inner,
  input  logic [PRG_OUT_W-1:0]          msk,
  input  logic [PRG_OUT_W-1:0]          outer,
  input  logic                          fix,
  input  logic                          fix8,
  input  logic                          fix16,
  input  core_e                         core,
  output logic [PRG_WINS*PRG_OUT_W-1:0] bank
);
  for (genvar w = 0; w < PRG_WINS; w++) begin : g_win
    localparam logic [1:0] WB = 2'(w);
    logic [PRG_OUT_W-1:0] inn;
    logic [PRG_OUT_W-1:0] b16;
    logic [PRG_OUT_W-1:0] b;

    assign inn = PRG_OUT_W'(inner[w*IN_W +: IN_W]);
    assign b16 = (inn & {1'b0, msk[PRG_OUT_W-1:1]}) | {1'b0, outer[PRG_OUT_W-1:1]};

    always_comb begin
      if (fix) begin
        if (fix8)       b = outer;
        else if (fix16) b = {outer[PRG_OUT_W-1:1], WB[0]};
        else            b = {outer[PRG_OUT_W-1:2], WB};
      end else if (core == CORE_SERIAL) begin
        b = {b16[PRG_OUT_W-2:0], WB[0]};
      end else begin
        b = (inn & msk) | outer;
      end
    end

    assign bank[w*PRG_OUT_W +: PRG_OUT_W] = b;
  end

  // R8
  fix8_same_chk: assert property (@(posedge clk) disable iff (por)
    (fix && fix8) |-> bank[PRG_OUT_W-1:0] == bank[PRG_WINS*PRG_OUT_W-1 -: PRG_OUT_W]);

  // R6
  outer_bits_chk: assert property (@(posedge clk) disable iff (por)
    (!fix && core != CORE_SERIAL) |-> (bank[PRG_OUT_W-1:0] & ~msk) == outer);
endmodule

// File: rtl/mbc_chr_map.sv
module mbc_chr_map
  import mbc_pkg::*;
(
  input  logic                          clk,
  input  logic                          por,
  input  logic [CHR_WINS*IN_W-1:0]      inner,
  input  logic [CHR_OUT_W-1:0]          msk,
  input  logic [CHR_OUT_W-1:0]          outer,
  input  logic                          fix,
  input  logic                          ram_sel,
  input  core_e                         core,
  output logic [CHR_WINS*CHR_OUT_W-1:0] bank
);
  for (genvar w = 0; w < CHR_WINS; w++) begin : g_win
    localparam logic [2:0] WB = 3'(w);
    logic [CHR_OUT_W-1:0] inn;
    logic [CHR_OUT_W-1:0] b4;
    logic [CHR_OUT_W-1:0] b;

    assign inn = CHR_OUT_W'(inner[w*IN_W +: IN_W]);
    assign b4  = (inn & {2'b0, msk[CHR_OUT_W-1:2]}) | {2'b0, outer[CHR_OUT_W-1:2]};

    always_comb begin
      if (ram_sel)                 b = CHR_OUT_W'(WB);
      else if (fix)                b = {outer[CHR_OUT_W-1:3], WB};
      else if (core == CORE_SERIAL) b = {b4[CHR_OUT_W-3:0], WB[1:0]};
      else                         b = (inn & msk) | outer;
    end

    assign bank[w*CHR_OUT_W +: CHR_OUT_W] = b;
  end

  // R11
  fix_run_chk: assert property (@(posedge clk) disable iff (por)
    (fix && !ram_sel) |->
      bank[CHR_WINS*CHR_OUT_W-1 -: CHR_OUT_W] == bank[CHR_OUT_W-1:0] + CHR_OUT_W'(CHR_WINS-1));

  // R9
  chr_outer_chk: assert property (@(posedge clk) disable iff (por)
    (!ram_sel && !fix && core != CORE_SERIAL) |-> (bank[CHR_OUT_W-1:0] & ~msk) == outer);
endmodule

// File: rtl/multicart_bank_combiner.sv
module multicart_bank_combiner
  import mbc_pkg::*;
#(
  parameter int         PRG_ROM_BANKS = 32,
  parameter int         CHR_ROM_BANKS = 32,
  parameter bit         HAS_CHR_RAM   = 1'b1,
  parameter int         DIP_W         = 8,
  parameter logic [3:0] WIN_NIB       = 4'h5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          por,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [REG_W-1:0]              cpu_wdata,
  input  logic                          cpu_wr,
  input  logic                          cpu_rd,
  output logic [REG_W-1:0]              cpu_rdata,
  input  logic [PRG_WINS*IN_W-1:0]      prg_inner,
  input  logic [CHR_WINS*IN_W-1:0]      chr_inner,
  output logic [PRG_WINS*PRG_OUT_W-1:0] prg_bank,
  output logic [CHR_WINS*CHR_OUT_W-1:0] chr_bank,
  output logic [1:0]                    core_sel,
  output logic                          chr_ram_sel,
  output logic [ADDR_W-1:0]             core_addr
);
  cfg_t                 cfg;
  logic [PRG_OUT_W-1:0] prg_and, prg_or;
  logic [CHR_OUT_W-1:0] chr_and, chr_or;
  logic                 fix_prg, fix_prg8, fix_prg16, fix_chr, ram_sel;
  core_e                core;

  mbc_regs #(.DIP_W(DIP_W), .DATA_W(REG_W), .WIN_NIB(WIN_NIB)) u_regs (
    .clk(clk), .rst(rst), .por(por),
    .addr_nib(cpu_addr[ADDR_W-1 -: 4]), .addr_sel(cpu_addr[1:0]),
    .wdata(cpu_wdata), .wr(cpu_wr), .rd(cpu_rd),
    .cfg(cfg), .rdata(cpu_rdata)
  );

  mbc_mask #(.PRG_ROM_BANKS(PRG_ROM_BANKS), .CHR_ROM_BANKS(CHR_ROM_BANKS),
             .HAS_CHR_RAM(HAS_CHR_RAM)) u_mask (
    .cfg(cfg), .prg_and(prg_and), .prg_or(prg_or),
    .chr_and(chr_and), .chr_or(chr_or),
    .fix_prg(fix_prg), .fix_prg8(fix_prg8), .fix_prg16(fix_prg16),
    .fix_chr(fix_chr), .ram_sel(ram_sel), .core(core)
  );

  mbc_prg_map u_prg (
    .clk(clk), .por(por), .inner(prg_inner), .msk(prg_and), .outer(prg_or),
    .fix(fix_prg), .fix8(fix_prg8), .fix16(fix_prg16), .core(core),
    .bank(prg_bank)
  );

  mbc_chr_map u_chr (
    .clk(clk), .por(por), .inner(chr_inner), .msk(chr_and), .outer(chr_or),
    .fix(fix_chr), .ram_sel(ram_sel), .core(core), .bank(chr_bank)
  );

  assign core_sel    = core;
  assign chr_ram_sel = ram_sel;

  always_comb begin
    core_addr = cpu_addr;
    if (core == CORE_TIMER && cpu_addr[11])
      core_addr[3:0] = {cpu_addr[2], cpu_addr[3], cpu_addr[0], cpu_addr[1]};
  end

  // R13
  addr_pass_chk: assert property (@(posedge clk) disable iff (por)
    (core_sel != 2'd2 || !cpu_addr[11]) |-> core_addr == cpu_addr);

  // R4
  core_code_chk: assert property (@(posedge clk) disable iff (por)
    core_sel != 2'd3);
endmodule

// File: tb/sim_multicart_bank_combiner.sv
`timescale 1ns/1ps
module sim_multicart_bank_combiner;
  localparam int PB = 16;
  localparam int CB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        por = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [31:0] prg_inner = '0;
  logic [63:0] chr_inner = '0;
  logic [31:0] prg_bank;
  logic [71:0] chr_bank;
  logic [1:0]  core_sel;
  logic        chr_ram_sel;
  logic [15:0] core_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;
  int m_cfg[4];
  int m_dip = 0, m_rstq = 0, m_rd = 0;

  always #2.5 clk = ~clk;

  multicart_bank_combiner #(.PRG_ROM_BANKS(PB), .CHR_ROM_BANKS(CB), .HAS_CHR_RAM(1'b1)) u0 (
    .clk(clk), .rst(rst), .por(por), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .prg_inner(prg_inner), .chr_inner(chr_inner), .prg_bank(prg_bank),
    .chr_bank(chr_bank), .core_sel(core_sel), .chr_ram_sel(chr_ram_sel),
    .core_addr(core_addr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference state, advanced at every rising edge.
  always @(posedge clk) begin
    int hit;
    hit = (cpu_addr[15:12] == 4'h5);
    if (por) begin
      for (int i = 0; i < 4; i++) m_cfg[i] = 0;
      m_dip = 0; m_rstq = 0; m_rd = 0;
    end else begin
      m_rd = (cpu_rd && hit) ? m_dip : 0;
      if (rst) begin
        for (int i = 0; i < 4; i++) m_cfg[i] = 0;
        if (!m_rstq) m_dip = (m_dip + 1) % 256;
      end else if (cpu_wr && hit) begin
        m_cfg[cpu_addr[1:0]] = cpu_wdata;
      end
      m_rstq = rst;
    end
    started = 1;
    cycles++;
  end

  function automatic int ram_on(); return m_cfg[2] % 2; endfunction
  function automatic int core_of();
    if ((m_cfg[0] / 2) % 2 == 0) return 0;
    if (m_cfg[0] % 2 == 1) return 2;
    return 1;
  endfunction
  function automatic int pmask();
    if ((m_cfg[2] / 16) % 2 == 1) return 0;
    if ((m_cfg[2] / 4) % 2 == 1) return 15;
    return 31;
  endfunction
  function automatic int pouter();
    int lim = ram_on() ? PB + CB - 1 : PB - 1;
    return (m_cfg[1] / 2) & lim & ~pmask();
  endfunction
  function automatic int cmask();
    if ((m_cfg[2] / 64) % 2 == 1) return 0;
    if ((m_cfg[2] / 32) % 2 == 1) return 127;
    if ((m_cfg[2] / 16) % 2 == 1) return 31;
    return 255;
  endfunction
  function automatic int couter();
    return (m_cfg[0] * 2) & ~cmask() & 511;
  endfunction

  function automatic int exp_prg(int w);
    int o = pouter(), m = pmask(), inn = prg_inner[w*8 +: 8];
    if ((m_cfg[2] / 16) % 2 == 1) begin
      if ((m_cfg[2] / 8) % 2 == 1) return o;
      if ((m_cfg[2] / 4) % 2 == 1) return (o / 2) * 2 + w % 2;
      return (o / 4) * 4 + w;
    end
    if (core_of() == 1) return ((inn & (m / 2)) | (o / 2)) * 2 + w % 2;
    return (inn & m) | o;
  endfunction

  function automatic int exp_chr(int w);
    int o = couter(), m = cmask(), inn = chr_inner[w*8 +: 8];
    if (ram_on()) return w;
    if ((m_cfg[2] / 64) % 2 == 1) return (o / 8) * 8 + w;
    if (core_of() == 1) return ((inn & (m / 4)) | (o / 4)) * 4 + w % 4;
    return (inn & m) | o;
  endfunction

  function automatic int exp_addr();
    int a = cpu_addr;
    if (core_of() == 2 && cpu_addr[11]) begin
      int lo = a % 16;
      int sw = ((lo / 2) % 2) + 2 * (lo % 2) + 4 * ((lo / 8) % 2) + 8 * ((lo / 4) % 2);
      return (a / 16) * 16 + sw;
    end
    return a;
  endfunction

  function automatic string prg_tag();
    if ((m_cfg[2] / 16) % 2 == 1) return "R8";
    if (core_of() == 1) return "R7";
    return "R6";
  endfunction
  function automatic string chr_tag();
    if (ram_on()) return "R12";
    if ((m_cfg[2] / 64) % 2 == 1) return "R11";
    if (core_of() == 1) return "R10";
    return "R9";
  endfunction

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (started) begin
      for (int w = 0; w < 4; w++) chk(prg_tag(), prg_bank[w*8 +: 8], exp_prg(w));
      for (int w = 0; w < 8; w++) chk(chr_tag(), chr_bank[w*9 +: 9], exp_chr(w));
      chk("R4", core_sel, core_of());
      chk("R12", chr_ram_sel, ram_on());
      chk("R13", core_addr, exp_addr());
      chk("R2", cpu_rdata, m_rd);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    prg_inner = {$urandom, $urandom} [31:0];
    chr_inner = {$urandom, $urandom};
  endtask
  task automatic wr(int a, int d);
    cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_wr = 1'b1;
    tick();
    cpu_wr = 1'b0;
  endtask
  task automatic rd(int a);
    cpu_addr = 16'(a); cpu_rd = 1'b1;
    tick();
    cpu_rd = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0s[7] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h5A, 8'h7F, 8'hFE};
    int r2s[12] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h40, 8'h20, 8'h30, 8'h01, 8'h05, 8'h60, 8'h19};
    int r1s[3] = '{8'h3E, 8'h1B, 8'hFF};
    repeat (3) tick();
    por = 1'b0;
    tick();
    // R3: counter zero after power clear, registers zero
    rd(16'h5123);
    @(negedge clk);
    chk("R3", cpu_rdata, 0);
    chk("R3", core_sel, 0);
    tick();

    // R1: write outside the window must not change the core select
    wr(16'h6000, 8'h03);
    @(negedge clk);
    chk("R1", core_sel, 0);
    tick();
    wr(16'h5F00, 8'h03);
    @(negedge clk);
    chk("R1", core_sel, 2);
    tick();

    // R13: timer core with address bit 11 set and clear
    cpu_addr = 16'h8805; tick();
    @(negedge clk);
    chk("R13", core_addr, 16'h880A);
    tick();
    cpu_addr = 16'h8005; tick();

    // R5: outer value limited by the ROM bank count, widened with CHR-RAM
    wr(16'h5001, 8'hFE);
    wr(16'h5002, 8'h18);
    @(negedge clk);
    chk("R5", prg_bank[7:0], 15);
    tick();
    wr(16'h5002, 8'h19);
    @(negedge clk);
    chk("R5", prg_bank[7:0], 31);
    chk("R12", chr_ram_sel, 1);
    tick();

    // Mode sweep across all cores and fixed modes
    foreach (r0s[i]) foreach (r2s[j]) foreach (r1s[k]) begin
      wr(16'h5000 + (i % 2) * 16'h0100, r0s[i]);
      wr(16'h5001, r1s[k]);
      wr(16'h5002, r2s[j]);
      wr(16'h5003, i * 17 + j);
      cpu_addr = (j % 2) ? 16'h9803 : 16'hF809;
      repeat (3) tick();
      rd(16'h5400 + j);
      rd(16'h4400);
    end

    // R3: reset rising edges advance the counter once each
    wr(16'h5000, 8'h02);
    rst = 1'b1; repeat (3) tick(); rst = 1'b0; tick();
    @(negedge clk);
    chk("R3", core_sel, 0);
    tick();
    rst = 1'b1; tick(); rst = 1'b0; tick();
    rd(16'h5000);
    @(negedge clk);
    chk("R3", cpu_rdata, 2);
    chk("R2", cpu_rdata, 2);
    tick();
    rd(16'h3000);
    @(negedge clk);
    chk("R2", cpu_rdata, 0);
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule